// File: doc/BRIEF.md
# Nibble-Mode Byte Reader for a Parallel Port Host

This block is the host side of a four-line reverse channel on a parallel printer port. The peripheral holds a byte behind a 2-to-1 nibble multiplexer. The host steers that multiplexer with one control line and reads the multiplexer output on the four upper status lines.

When the block gets a start request, it first points the multiplexer at the low half of the byte. It waits a programmable settle time and samples. It then points the multiplexer at the high half, waits again and samples. The two samples are packed into a byte. The status line that the port hardware inverts (one line, seen once in each nibble) is then flipped back. The byte is reported with a one-cycle valid strobe.

The status lines are asynchronous to the host clock, so they pass through a synchroniser before any sample is taken. Agreeing on the mode with the peripheral is left to other logic.

Top module: `nibble_reader`

## Requirements
- R1: After reset, `sel_o` is 1, `busy_o` is 0, `valid_o` is 0 and `byte_o` is 0.
- R2: A start request seen at a clock edge while idle begins a read. `busy_o` is 1 from that edge until the edge that raises `valid_o`, where it returns to 0.
- R3: `sel_o` is 1 (low nibble, multiplexer input A) while idle and during the first phase. It is 0 (high nibble, input B) during the second phase. It goes back to 1 when the byte is reported.
- R4: With settle value N captured at the start edge S, the low nibble is sampled at edge S+N+1. The high nibble is sampled at edge S+2N+2, and `valid_o` rises at that same edge.
- R5: `byte_o` bits 3..0 are the first sample and bits 7..4 are the second sample, each taken from status bits 7..4. The packed value is XORed with 0x88 (parameter `INV_MASK`) so that the inverted busy line, bit 3 of each nibble, is restored.
- R6: `valid_o` is high for exactly one cycle per read.
- R7: Start requests while `busy_o` is 1 are ignored. No extra read and no extra `valid_o` pulse results from them.
- R8: The status inputs pass through `SYNC_STAGES` flip-flops before sampling. A settle value of at least `SYNC_STAGES` yields the correct byte from a multiplexer that responds combinationally.
- R9: `settle_i` is captured at the start edge. Changing it during a read does not change that read's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to read one byte |
| settle_i | input | SET_W | Settle cycles after each change of the select line |
| stat_i | input | NIB_W | Status lines 7..4 as seen at the port |
| sel_o | output | 1 | Nibble select to the multiplexer (1 = low nibble) |
| busy_o | output | 1 | A read is in progress |
| valid_o | output | 1 | One-cycle strobe: `byte_o` holds a new byte |
| byte_o | output | 2*NIB_W | Corrected byte |

## Verification
A wrong phase state shows at `sel_o` at once. It appears as the select line falling too early or too late against the settle count, or as `busy_o` not dropping together with `valid_o`. The bench checks both at the exact edges derived from R4. A swapped nibble order, a wrong inversion mask or a short synchroniser corrupts `byte_o` on the first read with asymmetric data such as 0xA5 or 0x81. A stuck-on or missed restart guard produces an unexpected `valid_o` within one read time of the ignored request, and the scoreboard catches that.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } rd_state_e;
endpackage

// File: rtl/nrd_sync.sv
module nrd_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nrd_settle.sv
module nrd_settle #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   AST_CNT_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !load_i) |=> done_o); // R4
   AST_CNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(val_i))); // R4
endmodule

// File: rtl/nrd_pack.sv
module nrd_pack #(
   parameter int                  NIB_W    = 4,
   parameter logic [2*NIB_W-1:0]  INV_MASK = 'h88
) (
   input  logic [NIB_W-1:0]   lo_i,
   input  logic [NIB_W-1:0]   hi_i,
   output logic [2*NIB_W-1:0] byte_o
);
   assign byte_o = {hi_i, lo_i} ^ INV_MASK;
endmodule

// File: rtl/nibble_reader.sv
module nibble_reader
   import nrd_pkg::*;
#(
   parameter int                 NIB_W       = 4,
   parameter int                 SET_W       = 8,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [2*NIB_W-1:0] INV_MASK    = 'h88
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [SET_W-1:0]     settle_i,
   input  logic [NIB_W-1:0]     stat_i,
   output logic                 sel_o,
   output logic                 busy_o,
   output logic                 valid_o,
   output logic [2*NIB_W-1:0]   byte_o
);
   localparam int BYTE_W = 2 * NIB_W;

   generate
      if (NIB_W < 1) begin : g_bad_nib
         $error("NIB_W must be at least 1");
      end
      if (SET_W < 1) begin : g_bad_set
         $error("SET_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
   endgenerate

   rd_state_e          state_q;
   logic [SET_W-1:0]   settle_q;
   logic [NIB_W-1:0]   lo_q;
   logic [NIB_W-1:0]   stat_s;
   logic [BYTE_W-1:0]  packed_w;
   logic [BYTE_W-1:0]  byte_q;
   logic               sel_q;
   logic               valid_q;
   logic               cnt_load;
   logic               cnt_done;
   logic [SET_W-1:0]   cnt_val;

   nrd_sync #(.W(NIB_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(stat_i), .q_o(stat_s)
   );

   assign cnt_load = ((state_q == ST_IDLE) && start_i) ||
                     ((state_q == ST_LOW) && cnt_done);
   assign cnt_val  = (state_q == ST_IDLE) ? settle_i : settle_q;

   nrd_settle #(.CNT_W(SET_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .val_i(cnt_val),
      .done_o(cnt_done)
   );

   nrd_pack #(.NIB_W(NIB_W), .INV_MASK(INV_MASK)) u_pack (
      .lo_i(lo_q), .hi_i(stat_s), .byte_o(packed_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         settle_q <= '0;
         lo_q     <= '0;
         byte_q   <= '0;
         sel_q    <= 1'b1;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  settle_q <= settle_i;
                  sel_q    <= 1'b1;
                  state_q  <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (cnt_done) begin
                  lo_q    <= stat_s;
                  sel_q   <= 1'b0;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (cnt_done) begin
                  byte_q  <= packed_w;
                  valid_q <= 1'b1;
                  sel_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sel_o   = sel_q;
   assign busy_o  = (state_q != ST_IDLE);
   assign valid_o = valid_q;
   assign byte_o  = byte_q;

   AST_SEL_HI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> sel_o); // R3
   AST_SEL_FALL_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_o) |-> busy_o); // R3
   AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && sel_o)); // R2
   AST_VALID_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (!busy_o && $past(busy_o))); // R2
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R6
   AST_SETTLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(settle_q)); // R9
endmodule

// File: tb/nibble_reader_bench.sv
module nibble_reader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC_N     = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] settle_i = 8'd0;
   logic [3:0] stat_i;
   logic       sel_o, busy_o, valid_o;
   logic [7:0] byte_o;
   logic [7:0] dev_byte = 8'h00;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // peripheral-side multiplexer; the port hardware inverts status bit 7
   assign stat_i = (sel_o ? dev_byte[3:0] : dev_byte[7:4]) ^ 4'b1000;

   nibble_reader #(.SYNC_STAGES(SYNC_N)) u_nibble_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
      .stat_i(stat_i), .sel_o(sel_o), .busy_o(busy_o), .valid_o(valid_o),
      .byte_o(byte_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   // monitor: pops expected byte on every valid strobe
   always @(negedge clk) begin
      cycles++;
      if (rst_n && valid_o) begin
         if (exp_q.size() == 0) begin
            chk("R7 unexpected valid", 32'(byte_o), 32'hFFFF_FFFF);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R5 byte", 32'(byte_o), 32'(e));
         end
      end
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         finish_run();
      end
   end

   // driver: one read with settle n; disturb adds a start pulse and a settle change mid-read
   task automatic do_read(input logic [7:0] d, input int n, input bit disturb);
      @(negedge clk);
      dev_byte = d;
      settle_i = 8'(n);
      repeat (3) @(negedge clk);
      exp_q.push_back(d);
      start_i = 1'b1;
      @(negedge clk);              // after start edge S
      start_i = 1'b0;
      chk("R2 busy after start", 32'(busy_o), 32'd1);
      if (disturb) settle_i = 8'(n + 5);
      repeat (n) @(negedge clk);   // after S+n
      chk("R3 sel low phase", 32'(sel_o), 32'd1);
      @(negedge clk);              // after S+n+1
      chk("R4 sel switches at S+N+1", 32'(sel_o), 32'd0);
      if (disturb) start_i = 1'b1;
      repeat (n) @(negedge clk);   // after S+2n+1
      start_i = 1'b0;
      chk("R4 no valid before S+2N+2", 32'(valid_o), 32'd0);
      chk("R2 busy in high phase", 32'(busy_o), 32'd1);
      @(negedge clk);              // after S+2n+2
      chk("R4 valid at S+2N+2", 32'(valid_o), 32'd1);
      chk("R2 idle with valid", 32'(busy_o), 32'd0);
      chk("R3 sel returns high", 32'(sel_o), 32'd1);
      @(negedge clk);
      chk("R6 valid one cycle", 32'(valid_o), 32'd0);
      if (disturb) begin
         repeat (3 * n + 8) @(negedge clk);
         chk("R7 start ignored, stays idle", 32'(busy_o), 32'd0);
         chk("R9 settle change ignored", 32'(exp_q.size()), 32'd0);
      end
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 sel reset", 32'(sel_o), 32'd1);
      chk("R1 busy reset", 32'(busy_o), 32'd0);
      chk("R1 valid reset", 32'(valid_o), 32'd0);
      chk("R1 byte reset", 32'(byte_o), 32'd0);
      rst_n = 1'b1;
      do_read(8'hA5, 3, 1'b0);
      do_read(8'h00, 2, 1'b0);   // R8: minimum settle equals sync depth
      do_read(8'hFF, 2, 1'b0);
      do_read(8'h88, 4, 1'b0);
      do_read(8'h77, 5, 1'b0);
      do_read(8'h81, 3, 1'b1);   // R7 and R9 disturbance
      do_read(8'h3C, 6, 1'b0);
      for (int i = 0; i < 16; i++)
         do_read(8'((i * 37 + 11) & 8'hFF), 2 + (i % 4), (i % 5) == 0);
      repeat (5) @(negedge clk);
      chk("R5 all bytes reported", 32'(exp_q.size()), 32'd0);
      finish_run();
   end
endmodule